// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Comma-Driven Boundary Alignment

This block turns a one-bit serial stream, sampled once per bit clock, into parallel words of 8, 10, 16 or 20 bits. A word counter running on the bit clock marks each word boundary. At each boundary the block presents the finished word together with a one-cycle strobe. Logic downstream uses that strobe as its word-rate clock enable. After reset the counter starts from zero, so the first word boundary has no relation to the symbol framing of the incoming stream.

A slip request moves the word boundary one bit later. The counter holds its value for one bit cycle, so the next word takes one extra serial bit. An alignment controller drives slips by itself in the 10- and 20-bit modes. It looks at the earliest ten bits of each word for either polarity of the 10-bit comma. On a miss it issues one slip and then lets two words pass before it judges again. After three consecutive hits it reports alignment. An external slip input shares the same path, and any external slip drops the alignment status. The width select is taken in only while reset is asserted.

Top module: `deser_align`

## Requirements
- R1: `width_sel` selects the word length (0: 8 bits, 1: 10 bits, 2: 16 bits, 3: 20 bits) and is captured only while `rst_n` is low. Without slips, `word_stb` is high for exactly one cycle in every n bit cycles.
- R2: For a word whose last bit was sampled at clock edge c, `par_out[i]` holds the bit sampled at edge c-n+1+i, so bit 0 is the earliest. Bits n and above are zero. `par_out` and `word_stb` update at edge c itself and hold until the next word.
- R3: Let the slip request be `slip_in` OR `slip_pulse`. Each clock edge that samples it high makes the following bit cycle a held cycle. A held cycle does not advance the word counter, so the next boundary falls one bit later.
- R4: While `rst_n` is low, `par_out`, `word_stb`, `slip_pulse` and `aligned` are all zero. The first word after release is formed from the first n bits sampled after release.
- R5: A hit is a word whose `par_out[9:0]` equals 10'h17C or 10'h283. These are the two comma polarities, with bit 0 received first.
- R6: In the 10- and 20-bit modes, a judged word that is not a hit raises `slip_pulse` for one cycle. The next two words are not judged, so two controller slips are at least three word strobes apart.
- R7: `aligned` rises one cycle after the third consecutive judged hit. While `aligned` is high, the controller issues no slip.
- R8: An external `slip_in` clears `aligned` on the next cycle and restarts the search after two unjudged words.
- R9: In the 8- and 16-bit modes the controller stays idle: `slip_pulse` and `aligned` stay zero whatever the data.
- R10: Changing `width_sel` while `rst_n` is high does not change the word length until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset; captures the width select |
| width_sel | input | 2 | Word length code (see R1) |
| ser_in | input | 1 | Serial data bit |
| slip_in | input | 1 | External boundary slip request, one bit per high cycle |
| par_out | output | MAX_W | Parallel word, earliest bit in bit 0 |
| word_stb | output | 1 | One-cycle strobe marking a new word on `par_out` |
| slip_pulse | output | 1 | Slip issued by the alignment controller |
| aligned | output | 1 | Comma found at the word boundary in three consecutive words |

## Verification
A word counter that is off by even one count changes the spacing of `word_stb` and the contents of the first word after reset, so the error shows within n+1 cycles. A slip that is lost or applied twice moves every later word by one bit, and this mismatch appears at the very next strobe. A controller fault shows up in two ways. One is the number of slips before `aligned` rises. With d filler bits ahead of a comma stream, exactly d slips are expected. The other is the strobe gap between slips and the word on which `aligned` rises. Both are visible within a few words.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int unsigned LANE_W0  = 8;
    localparam int unsigned LANE_W1  = 10;
    localparam int unsigned LANE_W2  = 16;
    localparam int unsigned LANE_W3  = 20;
    localparam int unsigned COMMA_W  = 10;
    localparam logic [COMMA_W-1:0] COMMA_POS = 10'h17C;
    localparam logic [COMMA_W-1:0] COMMA_NEG = 10'h283;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LOCK   = 2'd2
    } align_st_e;

    function automatic int unsigned lane_width(input logic [1:0] code);
        case (code)
            2'd0:    return LANE_W0;
            2'd1:    return LANE_W1;
            2'd2:    return LANE_W2;
            default: return LANE_W3;
        endcase
    endfunction

    function automatic logic is_symbol_mode(input logic [1:0] code);
        return (lane_width(code) % COMMA_W) == 0;
    endfunction

endpackage

// File: rtl/deser_core.sv
module deser_core
    import deser_pkg::*;
#(
    parameter int unsigned MAX_W = 20,
    localparam int unsigned CNT_W = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       width_sel,
    input  logic             ser_in,
    input  logic             slip,
    output logic [MAX_W-1:0] par_out,
    output logic             word_stb,
    output logic             symbol_mode
);

    typedef struct packed {
        logic [MAX_W-1:0] shreg;
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic [1:0]       code;
        logic [MAX_W-1:0] par;
        logic             stb;
    } core_t;

    core_t q, d;
    logic [CNT_W:0]   wlen;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        wlen     = (CNT_W+1)'(lane_width(q.code));
        last_idx = CNT_W'(wlen - 1'b1);
        d        = q;
        d.shreg  = {ser_in, q.shreg[MAX_W-1:1]};
        d.pend   = slip;
        d.stb    = 1'b0;
        if (!q.pend) begin
            if (q.cnt == last_idx) begin
                d.cnt = '0;
                d.stb = 1'b1;
                d.par = d.shreg >> (MAX_W - wlen);
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (!rst_n) begin
            d      = '0;
            d.code = width_sel;
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign par_out     = q.par;
    assign word_stb    = q.stb;
    assign symbol_mode = is_symbol_mode(q.code);

    // R1: counter never passes the last index of the captured width
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= last_idx);
    // R1: strobes are single-cycle
    p_stb_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |=> !q.stb);
    // R3: a held cycle produces no word and leaves the counter alone
    p_hold_nostb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend |=> !q.stb);
    p_hold_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend |=> (q.cnt == $past(q.cnt)));
    // R10: width code stays fixed outside reset
    p_code_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(q.code));

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
    import deser_pkg::*;
#(
    parameter int unsigned HITS   = 3,
    parameter int unsigned SETTLE = 2,
    localparam int unsigned HW = $clog2(HITS + 1),
    localparam int unsigned SW = $clog2(SETTLE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               word_stb,
    input  logic [COMMA_W-1:0] boundary,
    input  logic               ext_slip,
    output logic               slip_req,
    output logic               locked
);

    typedef struct packed {
        align_st_e     st;
        logic [HW-1:0] hits;
        logic [SW-1:0] settle;
        logic          slip;
        logic          lock;
    } ctl_t;

    ctl_t q, d;
    logic hit;

    always_comb begin
        hit    = (boundary == COMMA_POS) || (boundary == COMMA_NEG);
        d      = q;
        d.slip = 1'b0;
        if (!enable) begin
            d = '0;
        end else if (ext_slip) begin
            d.st     = ST_SETTLE;
            d.settle = '0;
            d.hits   = '0;
            d.lock   = 1'b0;
        end else begin
            case (q.st)
                ST_HUNT: if (word_stb) begin
                    if (hit) begin
                        if (q.hits == HW'(HITS - 1)) begin
                            d.st   = ST_LOCK;
                            d.lock = 1'b1;
                            d.hits = '0;
                        end else begin
                            d.hits = q.hits + 1'b1;
                        end
                    end else begin
                        d.slip   = 1'b1;
                        d.st     = ST_SETTLE;
                        d.settle = '0;
                        d.hits   = '0;
                    end
                end
                ST_SETTLE: if (word_stb) begin
                    if (q.settle == SW'(SETTLE - 1)) begin
                        d.st     = ST_HUNT;
                        d.settle = '0;
                    end else begin
                        d.settle = q.settle + 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (!rst_n) d = '0;
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign slip_req = q.slip;
    assign locked   = q.lock;

    // R6: controller slips are single-cycle pulses
    p_slip_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.slip |=> !q.slip);
    // R7: lock rises only right after a judged word
    p_lock_on_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.lock) |-> $past(word_stb));
    // R7: no slip while locked
    p_no_slip_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |-> !q.slip);
    // R8: external slip drops lock
    p_ext_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_slip |=> !q.lock);
    // R9: idle in non-symbol widths
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!q.slip && !q.lock));

endmodule

// File: rtl/deser_align.sv
module deser_align
    import deser_pkg::*;
#(
    parameter int unsigned MAX_W  = 20,
    parameter int unsigned HITS   = 3,
    parameter int unsigned SETTLE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       width_sel,
    input  logic             ser_in,
    input  logic             slip_in,
    output logic [MAX_W-1:0] par_out,
    output logic             word_stb,
    output logic             slip_pulse,
    output logic             aligned
);

    logic slip_any;
    logic symbol_mode;

    assign slip_any = slip_in | slip_pulse;

    deser_core #(.MAX_W(MAX_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .width_sel   (width_sel),
        .ser_in      (ser_in),
        .slip        (slip_any),
        .par_out     (par_out),
        .word_stb    (word_stb),
        .symbol_mode (symbol_mode)
    );

    align_ctrl #(.HITS(HITS), .SETTLE(SETTLE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (symbol_mode),
        .word_stb (word_stb),
        .boundary (par_out[COMMA_W-1:0]),
        .ext_slip (slip_in),
        .slip_req (slip_pulse),
        .locked   (aligned)
    );

    // R4: outputs quiet in the cycle after a reset edge
    p_reset_quiet_r4: assert property (@(posedge clk)
        !rst_n |=> (!word_stb && !slip_pulse && !aligned && par_out == '0));

endmodule

// File: tb/tb_deser_align.sv
module tb_deser_align;

    localparam int MAX_W = 20;
    localparam logic [9:0] CP = 10'h17C;
    localparam logic [9:0] CN = 10'h283;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       width_sel = 2'd0;
    logic             ser_in = 1'b0;
    logic             slip_in = 1'b0;
    logic [MAX_W-1:0] par_out;
    logic             word_stb;
    logic             slip_pulse;
    logic             aligned;

    deser_align #(.MAX_W(MAX_W)) dut (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .ser_in(ser_in),
        .slip_in(slip_in), .par_out(par_out), .word_stb(word_stb),
        .slip_pulse(slip_pulse), .aligned(aligned)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    logic bits [0:4095];
    logic sdrv [0:4095];
    int   c = 0, n = 8, mcnt = 0;
    bit   active = 0, mpend = 0, pulse_prev = 0, aligned_prev = 0;
    int   pulses = 0, consec = 0, consec_at_rise = 0, stb_since = 0, stb_total = 0;
    bit   gap_armed = 0, rise_seen = 0, aligned_seen = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic comma_bit(input int k, input int d);
        int j;
        if (k < d) return 1'b0;
        j = (k - d) % 20;
        return (j < 10) ? CP[j] : CN[j-10];
    endfunction

    function automatic logic rnd_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // processes the clock edge that sampled bit c (R1, R2, R3 model)
    task automatic observe();
        logic [MAX_W-1:0] w;
        bit held, exp_stb;
        held = mpend;
        mpend = sdrv[c % 4096] | pulse_prev;
        exp_stb = 0;
        if (!held) begin
            if (mcnt == n - 1) begin exp_stb = 1; mcnt = 0; end
            else mcnt++;
        end
        chk(word_stb == exp_stb, "R1/R3 word_stb timing", word_stb, exp_stb);
        if (exp_stb) begin
            w = '0;
            for (int i = 0; i < n; i++) w[i] = bits[(c - n + 1 + i) % 4096];
            chk(par_out == w, "R2 parallel word", par_out, w);
            if (w[9:0] == CP || w[9:0] == CN) consec++; else consec = 0;
            stb_since++;
            stb_total++;
        end
        if (aligned) aligned_seen = 1;
        if (aligned && !aligned_prev) begin
            rise_seen = 1;
            consec_at_rise = consec;
            chk(consec >= 3, "R7 hits before aligned", consec, 3);
        end
        if (slip_pulse) begin
            pulses++;
            if (gap_armed) chk(stb_since >= 3, "R6 words between slips", stb_since, 3);
            gap_armed = 1;
            stb_since = 0;
        end
        pulse_prev = slip_pulse;
        aligned_prev = aligned;
    endtask

    task automatic tick(input logic b, input logic s);
        @(negedge clk);
        if (active) begin observe(); c++; end
        rst_n = 1'b1;
        ser_in = b;
        slip_in = s;
        bits[c % 4096] = b;
        sdrv[c % 4096] = s;
        active = 1;
    endtask

    task automatic do_reset(input logic [1:0] wc);
        @(negedge clk);
        rst_n = 1'b0; width_sel = wc; slip_in = 1'b0; ser_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(par_out == '0 && !word_stb && !slip_pulse && !aligned, "R4 reset state",
            {aligned, slip_pulse, word_stb, par_out}, 0);
        active = 0; c = 0; mcnt = 0; mpend = 0; pulse_prev = 0; aligned_prev = 0;
        n = (wc == 0) ? 8 : (wc == 1) ? 10 : (wc == 2) ? 16 : 20;
        pulses = 0; consec = 0; stb_since = 0; stb_total = 0;
        gap_armed = 0; rise_seen = 0; aligned_seen = 0;
    endtask

    initial begin
        int k;
        int p0;
        // R1, R2, R4: each width with an aligned comma stream (no slips needed)
        for (int wc = 0; wc < 4; wc++) begin
            do_reset(2'(wc));
            for (int t = 0; t < 4 * n + 1; t++) tick(comma_bit(t, 0), 1'b0);
            chk(stb_total == 4, "R1 word count per width", stb_total, 4);
            chk(pulses == 0, "R1 no slip on aligned stream", pulses, 0);
        end
        // R2, R3: random data with external slips, 8-bit and 16-bit
        for (int wc = 0; wc < 4; wc += 2) begin
            do_reset(2'(wc));
            for (int t = 0; t < 200; t++)
                tick(rnd_bit(), (t == 13 || t == 23 || t == 24 || t == 47 || t == 120) ? 1'b1 : 1'b0);
            chk(pulses == 0, "R3 no controller slips in narrow mode", pulses, 0);
        end
        // R9: narrow widths ignore misaligned commas
        for (int wc = 0; wc < 4; wc += 2) begin
            do_reset(2'(wc));
            for (int t = 0; t < 300; t++) tick(comma_bit(t, 3), 1'b0);
            chk(pulses == 0, "R9 no slip in narrow mode", pulses, 0);
            chk(!aligned_seen, "R9 never aligned in narrow mode", aligned_seen, 0);
        end
        // R5, R6, R7, R8: search from every phase offset, 10- and 20-bit
        for (int wc = 1; wc < 4; wc += 2) begin
            for (int d = 0; d < 10; d++) begin
                do_reset(2'(wc));
                k = 0;
                while (!rise_seen && k < 2000) begin tick(comma_bit(k, d), 1'b0); k++; end
                chk(rise_seen, "R7 aligned reached", rise_seen, 1);
                chk(pulses == d, "R5/R6 slip count equals offset", pulses, d);
                if (d == 0) chk(consec_at_rise == 3, "R7 third hit locks", consec_at_rise, 3);
                p0 = pulses;
                for (int t = 0; t < 80; t++) begin tick(comma_bit(k, d), 1'b0); k++; end
                chk(pulses == p0, "R7 no slip while aligned", pulses, p0);
                chk(aligned == 1'b1, "R7 aligned holds", aligned, 1);
                if (d == 3) begin
                    tick(comma_bit(k, d), 1'b1); k++;
                    tick(comma_bit(k, d), 1'b0); k++;
                    tick(comma_bit(k, d), 1'b0); k++;
                    chk(aligned == 1'b0, "R8 external slip clears aligned", aligned, 0);
                    pulses = 0; rise_seen = 0; gap_armed = 0;
                    while (!rise_seen && k < 4000) begin tick(comma_bit(k, d), 1'b0); k++; end
                    chk(rise_seen, "R8 realigns after external slip", rise_seen, 1);
                    chk(pulses == 9, "R8 slips to recover", pulses, 9);
                end
            end
        end
        // R10: width change outside reset has no effect until next reset
        do_reset(2'd0);
        for (int t = 0; t < 161; t++) begin
            if (t == 40) width_sel = 2'd3;
            tick(rnd_bit(), 1'b0);
        end
        chk(stb_total == 20, "R10 width unchanged without reset", stb_total, 20);
        do_reset(2'd3);
        for (int t = 0; t < 41; t++) tick(comma_bit(t, 0), 1'b0);
        chk(stb_total == 2, "R10 new width after reset", stb_total, 2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule